// File: doc/BRIEF.md
# Dual-Channel Configuration Register Bank with Staged Commit

This block holds the byte-wide configuration state of a receiver with two channels, I and Q. A serial-port decoder drives it through a plain parallel port: an address, a data byte, a write strobe and a registered read byte. Most registers take effect as soon as they are written. The per-channel registers (common-mode buffer enable and DC offset) work differently. They are written indirectly: a channel-select register names the channel copies that a write lands in. Those copies are staging registers. The values reach the live outputs only when software writes a 1 to the commit bit.

A self-clearing soft-reset bit in the port-format register returns every other register to its default value. The port-format register itself keeps the value written in the same cycle. The block drives the live per-channel offsets and buffer enables, the three path-bypass flags and the two port-format flags.

Top module: `cfgbank_top`

## Requirements
- R1: Synchronous reset (`rst` high) clears every output, including `rdata`, to 0. It also clears the staged per-channel values and sets the channel select to 2'b01.
- R2: Address 0x05 bits [1:0] hold the channel select: 00 selects no channel, 01 selects I, 10 selects Q and 11 selects both. Bits [7:2] read as 0.
- R3: A write to 0x0F (bit 0, buffer enable) or to 0x10 (bits [5:0], offset) changes only the staged copies of the selected channels. The live outputs do not change on that write.
- R4: A write to 0xFF with bit 0 set copies the staged values of both channels to the live registers at that clock edge. The outputs show the new values from the next cycle.
- R5: With channel select 00, writes to 0x0F and 0x10 are dropped. A following commit leaves the live outputs unchanged.
- R6: The offset is a 6-bit two's-complement value, from 011111 (+31) to 100000 (-32). It is driven to the channel output unchanged.
- R7: At address 0x00, bit 7 or bit 0 sets the bidirectional-data flag, and bit 6 or bit 1 sets the LSB-first flag. A read returns each flag in both of its positions.
- R8: A write to 0x00 with bit 5 or bit 2 set performs a soft reset. All registers other than 0x00 return to their R1 values, and 0x00 takes the flags written in that same write.
- R9: The soft-reset bits of 0x00 and the commit bit of 0xFF are self-clearing. They always read back as 0.
- R10: Address 0x30 holds the bypass flags: bit 5 for the decimator, bit 4 for interpolator 1 and bit 3 for interpolator 0. The other bits read as 0.
- R11: A read of 0x0F or 0x10 returns the live value of the lowest-numbered selected channel (I before Q), or 0 when no channel is selected.
- R12: `rdata` shows the contents of the address presented one cycle earlier. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sdio_bidir | output | 1 | Bidirectional-data flag |
| lsb_first | output | 1 | LSB-first flag |
| bp_decim | output | 1 | Decimator bypass |
| bp_interp1 | output | 1 | Interpolator 1 bypass |
| bp_interp0 | output | 1 | Interpolator 0 bypass |
| i_cmbuf_en | output | 1 | Live I buffer enable |
| q_cmbuf_en | output | 1 | Live Q buffer enable |
| i_dc_offset | output | 6 | Live I offset, two's complement |
| q_dc_offset | output | 6 | Live Q offset, two's complement |

## Verification
A wrong staged value stays hidden until a commit. Only the live outputs one cycle after the 0xFF write, or a read-back of the channel address, reveal it. The bench therefore always pairs a commit with a check of both channel outputs and a read of the channel address.

A bad select decode shows on the next commit as a change in the wrong channel. A faulty soft reset shows in the cycle after the 0x00 write as a nonzero bypass flag or offset, or as a channel select other than 01.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 6;
  localparam int NCH    = 2;
  localparam logic [BYTE_W-1:0] ADR_PORT  = 8'h00;
  localparam logic [BYTE_W-1:0] ADR_CSEL  = 8'h05;
  localparam logic [BYTE_W-1:0] ADR_CMBUF = 8'h0F;
  localparam logic [BYTE_W-1:0] ADR_OFFS  = 8'h10;
  localparam logic [BYTE_W-1:0] ADR_BYP   = 8'h30;
  localparam logic [BYTE_W-1:0] ADR_UPD   = 8'hFF;
  localparam logic [NCH-1:0]    CSEL_DEF  = 2'b01;
endpackage

// File: rtl/cfgbank_port.sv
module cfgbank_port (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [5:0] wbits,   // {d7,d6,d5,d2,d1,d0}
  output logic       bidir,
  output logic       lsbf,
  output logic       soft_rst,
  output logic [7:0] rd_byte
);
  logic hi_bidir, hi_lsb, hi_rst, lo_rst, lo_lsb, lo_bidir;
  assign {hi_bidir, hi_lsb, hi_rst, lo_rst, lo_lsb, lo_bidir} = wbits;

  // self-clearing: the reset bit is never stored, so every write carrying it is a rising edge
  assign soft_rst = we && (hi_rst || lo_rst);

  always_ff @(posedge clk) begin
    if (rst) begin
      bidir <= 1'b0;
      lsbf  <= 1'b0;
    end else if (we) begin
      bidir <= hi_bidir || lo_bidir;
      lsbf  <= hi_lsb || lo_lsb;
    end
  end

  assign rd_byte = {bidir, lsbf, 4'b0000, lsbf, bidir};

  assert_keep_R8: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (bidir == $past(hi_bidir || lo_bidir)) && (lsbf == $past(hi_lsb || lo_lsb)));
endmodule

// File: rtl/cfgbank_misc.sv
module cfgbank_misc #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           soft_rst,
  input  logic           we_csel,
  input  logic           we_byp,
  input  logic [NCH-1:0] csel_in,
  input  logic [2:0]     byp_in,
  output logic [NCH-1:0] csel,
  output logic [2:0]     byp
);
  localparam logic [NCH-1:0] CSEL_RST = NCH'(1);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      csel <= CSEL_RST;
      byp  <= '0;
    end else begin
      if (we_csel) csel <= csel_in;
      if (we_byp)  byp  <= byp_in;
    end
  end

  assert_srst_defaults_R8: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (csel == CSEL_RST) && (byp == 3'b000));
endmodule

// File: rtl/cfgbank_chan.sv
module cfgbank_chan #(
  parameter int OFS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             stage_cm,
  input  logic             stage_ofs,
  input  logic             commit,
  input  logic             cm_in,
  input  logic [OFS_W-1:0] ofs_in,
  output logic             cm_act,
  output logic [OFS_W-1:0] ofs_act
);
  logic             cm_sh;
  logic [OFS_W-1:0] ofs_sh;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cm_sh   <= 1'b0;
      ofs_sh  <= '0;
      cm_act  <= 1'b0;
      ofs_act <= '0;
    end else begin
      if (stage_cm)  cm_sh  <= cm_in;
      if (stage_ofs) ofs_sh <= ofs_in;
      if (commit) begin
        cm_act  <= cm_sh;
        ofs_act <= ofs_sh;
      end
    end
  end

  assert_live_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!commit && !soft_rst) |=> $stable(ofs_act) && $stable(cm_act));
  assert_commit_copy_R4: assert property (@(posedge clk) disable iff (rst)
    (commit && !soft_rst) |=> (ofs_act == $past(ofs_sh)) && (cm_act == $past(cm_sh)));
  assert_stage_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (!stage_ofs && !soft_rst) |=> $stable(ofs_sh));
endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       sdio_bidir,
  output logic       lsb_first,
  output logic       bp_decim,
  output logic       bp_interp1,
  output logic       bp_interp0,
  output logic       i_cmbuf_en,
  output logic       q_cmbuf_en,
  output logic [5:0] i_dc_offset,
  output logic [5:0] q_dc_offset
);
  localparam int PAD_OFS = BYTE_W - OFS_W;
  localparam int PAD_SEL = BYTE_W - NCH;

  logic             soft_rst, commit;
  logic [7:0]       port_byte;
  logic [NCH-1:0]   csel;
  logic [2:0]       byp;
  logic             cm_act  [NCH];
  logic [OFS_W-1:0] ofs_act [NCH];
  logic             hit_cm, hit_ofs;
  logic [7:0]       rd_next;

  assign hit_cm  = wr_en && (addr == ADR_CMBUF);
  assign hit_ofs = wr_en && (addr == ADR_OFFS);
  assign commit  = wr_en && (addr == ADR_UPD) && wdata[0];

  cfgbank_port u_port (
    .clk(clk), .rst(rst),
    .we(wr_en && (addr == ADR_PORT)),
    .wbits({wdata[7:5], wdata[2:0]}),
    .bidir(sdio_bidir), .lsbf(lsb_first),
    .soft_rst(soft_rst), .rd_byte(port_byte)
  );

  cfgbank_misc #(.NCH(NCH)) u_misc (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .we_csel(wr_en && (addr == ADR_CSEL)),
    .we_byp(wr_en && (addr == ADR_BYP)),
    .csel_in(wdata[NCH-1:0]), .byp_in(wdata[5:3]),
    .csel(csel), .byp(byp)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cfgbank_chan #(.OFS_W(OFS_W)) u_ch (
      .clk(clk), .rst(rst), .soft_rst(soft_rst),
      .stage_cm(hit_cm && csel[c]),
      .stage_ofs(hit_ofs && csel[c]),
      .commit(commit),
      .cm_in(wdata[0]), .ofs_in(wdata[OFS_W-1:0]),
      .cm_act(cm_act[c]), .ofs_act(ofs_act[c])
    );
  end

  assign {bp_decim, bp_interp1, bp_interp0} = byp;
  assign i_cmbuf_en  = cm_act[0];
  assign q_cmbuf_en  = cm_act[1];
  assign i_dc_offset = ofs_act[0];
  assign q_dc_offset = ofs_act[1];

  always_comb begin
    rd_next = '0;
    case (addr)
      ADR_PORT: rd_next = port_byte;
      ADR_CSEL: rd_next = {{PAD_SEL{1'b0}}, csel};
      ADR_BYP:  rd_next = {2'b00, byp, 3'b000};
      ADR_CMBUF: begin
        for (int c = NCH - 1; c >= 0; c--)
          if (csel[c]) rd_next = {7'd0, cm_act[c]};
      end
      ADR_OFFS: begin
        for (int c = NCH - 1; c >= 0; c--)
          if (csel[c]) rd_next = {{PAD_OFS{1'b0}}, ofs_act[c]};
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  assert_upd_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (addr == ADR_UPD) |=> (rdata == 8'h00));
endmodule

// File: tb/sim_cfgbank_top.sv
module sim_cfgbank_top;
  logic       clk = 1'b0;
  logic       rst, wr_en;
  logic [7:0] addr, wdata, rdata;
  logic       sdio_bidir, lsb_first, bp_decim, bp_interp1, bp_interp0;
  logic       i_cmbuf_en, q_cmbuf_en;
  logic [5:0] i_dc_offset, q_dc_offset;

  always #10 clk = ~clk;  // 50 MHz

  cfgbank_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .sdio_bidir(sdio_bidir), .lsb_first(lsb_first), .bp_decim(bp_decim),
    .bp_interp1(bp_interp1), .bp_interp0(bp_interp0),
    .i_cmbuf_en(i_cmbuf_en), .q_cmbuf_en(q_cmbuf_en),
    .i_dc_offset(i_dc_offset), .q_dc_offset(q_dc_offset)
  );

  typedef struct { logic [7:0] exp; string req; logic [7:0] a; } rd_item_t;
  rd_item_t sbq[$];
  int total = 0, bad = 0;
  logic rd_req = 1'b0, mon_vld = 1'b0;
  bit done = 1'b0;

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: read result appears one edge after the address
  always @(posedge clk) mon_vld <= rd_req;
  always @(negedge clk) begin
    if (mon_vld) begin
      if (sbq.size() == 0) begin
        total++; bad++;
        $display("FAIL R12: actual=%h expected=none (empty scoreboard)", rdata);
      end else begin
        rd_item_t it;
        it = sbq.pop_front();
        check8($sformatf("%s read %h", it.req, it.a), rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; rd_req = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    rd_item_t it;
    @(negedge clk);
    addr = a; wr_en = 1'b0; rd_req = 1'b1;
    it.exp = exp; it.req = req; it.a = a;
    sbq.push_back(it);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic chk_ch(input string req, input logic [5:0] ei, input logic [5:0] eq,
                        input logic ci, input logic cq);
    check8({req, " i_ofs"}, {2'b00, i_dc_offset}, {2'b00, ei});
    check8({req, " q_ofs"}, {2'b00, q_dc_offset}, {2'b00, eq});
    check8({req, " i_cm"},  {7'd0, i_cmbuf_en}, {7'd0, ci});
    check8({req, " q_cm"},  {7'd0, q_cmbuf_en}, {7'd0, cq});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; addr = 8'h00; wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_ch("R1", 6'h00, 6'h00, 1'b0, 1'b0);
    check8("R1 rdata", rdata, 8'h00);
    check8("R1 flags", {3'b0, sdio_bidir, lsb_first, bp_decim, bp_interp1, bp_interp0}, 8'h00);
    rd(8'h05, 8'h01, "R1 csel default");
    // R3 staged only, R4 commit
    wr(8'h10, 8'h1F);
    chk_ch("R3 staged", 6'h00, 6'h00, 1'b0, 1'b0);
    rd(8'h10, 8'h00, "R3 live unchanged");
    wr(8'hFF, 8'h01);
    chk_ch("R4 commit I", 6'h1F, 6'h00, 1'b0, 1'b0);
    rd(8'hFF, 8'h00, "R9 update self-clear");
    rd(8'h10, 8'h1F, "R11 I offset");
    // Q channel, -32
    wr(8'h05, 8'h02);
    wr(8'h10, 8'h20);
    wr(8'h0F, 8'h01);
    chk_ch("R3 Q staged", 6'h1F, 6'h00, 1'b0, 1'b0);
    wr(8'hFF, 8'h01);
    chk_ch("R4 commit Q", 6'h1F, 6'h20, 1'b0, 1'b1);
    check8("R6 q -32", 8'($signed(q_dc_offset)), 8'hE0);
    rd(8'h10, 8'h20, "R11 Q only");
    rd(8'h0F, 8'h01, "R11 Q cm");
    wr(8'h05, 8'h03);
    rd(8'h05, 8'h03, "R2 csel both");
    rd(8'h10, 8'h1F, "R11 lowest I");
    rd(8'h0F, 8'h00, "R11 lowest I cm");
    // R2 both
    wr(8'h10, 8'h3F);
    wr(8'hFF, 8'h01);
    chk_ch("R2 both", 6'h3F, 6'h3F, 1'b0, 1'b1);
    check8("R6 i -1", 8'($signed(i_dc_offset)), 8'hFF);
    // R5 none selected
    wr(8'h05, 8'h00);
    wr(8'h10, 8'h05);
    wr(8'h0F, 8'h01);
    wr(8'hFF, 8'h01);
    chk_ch("R5 none", 6'h3F, 6'h3F, 1'b0, 1'b1);
    rd(8'h10, 8'h00, "R11 none selected");
    rd(8'h05, 8'h00, "R2 csel none");
    // R10 bypass
    wr(8'h30, 8'hFF);
    check8("R10 flags", {5'b0, bp_decim, bp_interp1, bp_interp0}, 8'h07);
    rd(8'h30, 8'h38, "R10 readback");
    wr(8'h30, 8'h10);
    check8("R10 int1 only", {5'b0, bp_decim, bp_interp1, bp_interp0}, 8'h02);
    // R7 mirroring
    wr(8'h00, 8'h01);
    check8("R7 bidir low bit", {6'b0, sdio_bidir, lsb_first}, 8'h02);
    rd(8'h00, 8'h81, "R7 mirror bidir");
    wr(8'h00, 8'h40);
    check8("R7 lsb high bit", {6'b0, sdio_bidir, lsb_first}, 8'h01);
    rd(8'h00, 8'h42, "R7 mirror lsb");
    // R8 soft reset
    wr(8'h05, 8'h03);
    wr(8'h10, 8'h11);
    wr(8'h00, 8'hA0);
    chk_ch("R8 soft reset", 6'h00, 6'h00, 1'b0, 1'b0);
    check8("R8 keep port", {3'b0, sdio_bidir, lsb_first, bp_decim, bp_interp1, bp_interp0}, 8'h10);
    rd(8'h00, 8'h81, "R9 reset bit self-clear");
    rd(8'h05, 8'h01, "R8 csel default");
    rd(8'h30, 8'h00, "R8 bypass default");
    wr(8'hFF, 8'h01);
    chk_ch("R8 shadow cleared", 6'h00, 6'h00, 1'b0, 1'b0);
    wr(8'h00, 8'h04);
    check8("R8 low reset bit", {6'b0, sdio_bidir, lsb_first}, 8'h00);
    // R12 unmapped
    rd(8'h42, 8'h00, "R12 unmapped");
    rd(8'h05, 8'h01, "R12 latency");
    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      total++; bad++;
      $display("FAIL R12: actual=%0d expected=0 pending reads", sbq.size());
    end
    finish_run();
  end
endmodule